// File: doc/BRIEF.md
# Syntax Element Binarizer with Context Indexing

This block turns one syntax-element value at a time into a serial stream of binary decisions (bins) for a downstream binary arithmetic coder. A descriptor arrives on a valid/ready pair. It carries the value, a method code, one shared parameter (cutoff or field length), an Exp-Golomb order, a chain flag, a bypass flag, a 9-bit context offset and a row pointer into a small context-increment table. A single state machine steps through whichever encoder the method selects. All encoders feed one shared output path, so exactly one bin leaves per accepted push.

Each bin carries its position within the element (starting at zero) and either a context index or a bypass mark. The context index is the offset plus an increment looked up from the table, with the row taken from the descriptor and the column taken from the bin position. The output side pushes into a FIFO. While that FIFO reports full, the block holds the current bin. A new descriptor is taken only once the previous element has no bins left to push.

Top module: `sebin_binarizer`

## Requirements
- R1: Method code 0 (unary) emits `value` one-bins followed by a single zero-bin.
- R2: Method code 1 (truncated unary, cutoff `param`) emits min(value, param) one-bins, followed by a zero-bin only when value < param. Value equal to the cutoff therefore ends without a zero, and param = 0 without chaining gives no bins.
- R3: Method code 2 (Exp-Golomb of order k = `korder`): while the remainder is at least 2^k, emit a one, subtract 2^k and increment k. Then emit a zero, then the low k bits of the remainder, most significant first.
- R4: Method code 3 (fixed length, width `param`) emits the low `param` bits of the value, least significant bit first. Width 0 gives no bins.
- R5: With method 1 and the chain flag set, a value at or above the cutoff is followed by an Exp-Golomb suffix of order `korder` coding value − cutoff. Suffix bins are always marked bypass.
- R6: Bin index starts at 0 for the first bin of each element and rises by one per bin across prefix and suffix.
- R7: For a context-coded bin, the context index is (offset + row + min(bin index, 5)) mod 512. The table entry at row r and column c is r + c, with 6 columns, and the column saturates at 5.
- R8: When the descriptor's bypass flag is set, or the bin belongs to a chained suffix, `out_bypass` is 1 and `out_ctx` is 0.
- R9: While `out_full` is high no bin is pushed, and the presented bin and its index stay unchanged.
- R10: `in_ready` stays low from the acceptance of a descriptor until its last bin has been pushed, and is high in the cycle after that push.
- R11: After reset `in_ready` is 1 and `out_push` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Block idle, descriptor taken this cycle if valid |
| in_value | input | 16 | Element value |
| in_method | input | 2 | 0 unary, 1 truncated unary, 2 Exp-Golomb, 3 fixed length |
| in_param | input | 8 | Cutoff (method 1) or width (method 3) |
| in_korder | input | 4 | Exp-Golomb order |
| in_chain | input | 1 | Append Exp-Golomb suffix after truncated unary |
| in_bypass | input | 1 | All bins of the element are bypass |
| in_ctx_off | input | 9 | Context offset |
| in_ctx_row | input | 3 | Row of the increment table |
| out_full | input | 1 | Downstream FIFO full |
| out_push | output | 1 | Bin written this cycle |
| out_bin | output | 1 | Bin value |
| out_bypass | output | 1 | Bin is bypass coded |
| out_ctx | output | 9 | Context index (0 for bypass) |
| out_bin_idx | output | 8 | Bin position within the element |

## Verification
A vector table drives every method with ordinary values, zero values and values at and beyond the truncated-unary cutoff. This separates the presence or absence of the terminating zero from simple clamping. Exp-Golomb vectors with orders 0 to 3 distinguish how the prefix grows from the suffix width and bit order. A fixed-length vector with an asymmetric 16-bit pattern exposes any reversal of bit order. Chained vectors check the cutoff-with-suffix case, the below-cutoff case with no suffix, and the zero-cutoff case that emits only the suffix. A long unary element at a high offset shows both column saturation and the 9-bit wrap of the context sum. Three full-signal patterns (none, alternating, one cycle in three) show that stalls neither drop nor repeat bins.

// File: rtl/sebin_binarizer.sv
module sebin_binarizer #(
  parameter int VAL_W = 16,
  parameter int PRM_W = 8,
  parameter int KW    = 4,
  parameter int OFF_W = 9,
  parameter int NROW  = 8,
  parameter int NCOL  = 6,
  parameter int BIW   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [VAL_W-1:0]        in_value,
  input  logic [1:0]              in_method,
  input  logic [PRM_W-1:0]        in_param,
  input  logic [KW-1:0]           in_korder,
  input  logic                    in_chain,
  input  logic                    in_bypass,
  input  logic [OFF_W-1:0]        in_ctx_off,
  input  logic [$clog2(NROW)-1:0] in_ctx_row,
  input  logic                    out_full,
  output logic                    out_push,
  output logic                    out_bin,
  output logic                    out_bypass,
  output logic [OFF_W-1:0]        out_ctx,
  output logic [BIW-1:0]          out_bin_idx
);
  localparam int RW  = $clog2(NROW);
  localparam int UW  = VAL_W + 2;
  localparam int KKW = $clog2(UW) + 1;
  localparam int IXW = $clog2(NROW * NCOL);

  localparam logic [1:0] M_UN = 2'd0, M_TU = 2'd1, M_EG = 2'd2, M_FL = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_PFX, S_EGP, S_EGS, S_FL} st_t;

  st_t              st;
  logic [VAL_W-1:0] cnt, lim, sh;
  logic [PRM_W-1:0] flen;
  logic             hz, chn, byp, sfx;
  logic [UW-1:0]    u;
  logic [KKW-1:0]   kk;
  logic [OFF_W-1:0] off;
  logic [RW-1:0]    row;
  logic [BIW-1:0]   bidx;

  logic [OFF_W-1:0] rom [NROW*NCOL];
  for (genvar r = 0; r < NROW; r++) begin : g_row
    for (genvar c = 0; c < NCOL; c++) begin : g_col
      assign rom[r*NCOL+c] = OFF_W'(r + c);
    end
  end

  logic [UW-1:0] pw, us;
  logic          bit_q, last, to_sfx;

  assign pw = UW'(1) << kk;
  assign us = u >> (kk - 1'b1);

  always_comb begin
    bit_q = 1'b0;
    last  = 1'b0;
    case (st)
      S_PFX: begin
        bit_q = cnt < lim;
        last  = bit_q ? ((cnt + 1'b1 == lim) && !hz) : 1'b1;
      end
      S_EGP: begin
        bit_q = u >= pw;
        last  = !bit_q && (kk == '0);
      end
      S_EGS: begin
        bit_q = us[0];
        last  = kk == KKW'(1);
      end
      S_FL: begin
        bit_q = sh[0];
        last  = cnt + 1'b1 == VAL_W'(flen);
      end
      default: ;
    endcase
  end

  assign to_sfx = (st == S_PFX) && last && chn && !hz;

  assign in_ready   = st == S_IDLE;
  assign out_push   = (st != S_IDLE) && !out_full;
  assign out_bin    = bit_q;
  assign out_bypass = byp | sfx;
  assign out_bin_idx = bidx;

  logic [BIW-1:0] col;
  logic [IXW-1:0] ix;
  assign col = (bidx >= BIW'(NCOL - 1)) ? BIW'(NCOL - 1) : bidx;
  assign ix  = IXW'(row) * IXW'(NCOL) + IXW'(col);
  assign out_ctx = out_bypass ? '0 : off + rom[ix];

  logic [VAL_W-1:0] cut;
  logic             below;
  assign cut   = VAL_W'(in_param);
  assign below = in_value < cut;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      lim  <= '0;
      sh   <= '0;
      flen <= '0;
      hz   <= 1'b0;
      chn  <= 1'b0;
      byp  <= 1'b0;
      sfx  <= 1'b0;
      u    <= '0;
      kk   <= '0;
      off  <= '0;
      row  <= '0;
      bidx <= '0;
    end else if (st == S_IDLE) begin
      if (in_valid) begin
        cnt  <= '0;
        bidx <= '0;
        sh   <= in_value;
        flen <= in_param;
        byp  <= in_bypass;
        off  <= in_ctx_off;
        row  <= in_ctx_row;
        kk   <= KKW'(in_korder);
        sfx  <= 1'b0;
        chn  <= in_chain && (in_method == M_TU);
        u    <= (in_method == M_EG) ? UW'(in_value) : UW'(in_value) - UW'(cut);
        lim  <= (in_method == M_UN || below) ? in_value : cut;
        hz   <= (in_method == M_UN) || below;
        case (in_method)
          M_UN: st <= S_PFX;
          M_TU: begin
            if (below || cut != '0) st <= S_PFX;
            else if (in_chain) begin
              st  <= S_EGP;
              sfx <= 1'b1;
            end
          end
          M_EG: st <= S_EGP;
          M_FL: if (in_param != '0) st <= S_FL;
          default: ;
        endcase
      end
    end else if (!out_full) begin
      if (bidx != {BIW{1'b1}}) bidx <= bidx + 1'b1;
      case (st)
        S_PFX: begin
          if (bit_q) cnt <= cnt + 1'b1;
          if (to_sfx) begin
            st  <= S_EGP;
            sfx <= 1'b1;
          end else if (last) st <= S_IDLE;
        end
        S_EGP: begin
          if (bit_q) begin
            u  <= u - pw;
            kk <= kk + 1'b1;
          end else st <= (kk == '0) ? S_IDLE : S_EGS;
        end
        S_EGS: begin
          kk <= kk - 1'b1;
          if (last) st <= S_IDLE;
        end
        S_FL: begin
          sh  <= sh >> 1;
          cnt <= cnt + 1'b1;
          if (last) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r6_first_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_bin_idx == '0));

  a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_push && !last && out_bin_idx != {BIW{1'b1}}) |=> (out_bin_idx == $past(out_bin_idx) + 1'b1));

  a_r9_hold_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && out_full) |=> ($stable(out_bin_idx) && $stable(out_bin) && $stable(out_ctx)));

  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (out_push && !last) |=> !in_ready);

  a_r10_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_push && last && !to_sfx) |=> in_ready);

  a_r2_zero_ends_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    (out_push && st == S_PFX && !out_bin) |=> in_ready);

  a_r8_bypass_no_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    (out_push && sfx) |-> (out_bypass && out_ctx == '0));
endmodule

// File: tb/sebin_binarizer_tb.sv
module sebin_binarizer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [15:0] in_value = '0;
  logic [1:0] in_method = '0;
  logic [7:0] in_param = '0;
  logic [3:0] in_korder = '0;
  logic       in_chain = 1'b0;
  logic       in_bypass = 1'b0;
  logic [8:0] in_ctx_off = '0;
  logic [2:0] in_ctx_row = '0;
  logic       out_full = 1'b0;
  logic       out_push, out_bin, out_bypass;
  logic [8:0] out_ctx;
  logic [7:0] out_bin_idx;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  sebin_binarizer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_method(in_method), .in_param(in_param),
    .in_korder(in_korder), .in_chain(in_chain), .in_bypass(in_bypass),
    .in_ctx_off(in_ctx_off), .in_ctx_row(in_ctx_row), .out_full(out_full),
    .out_push(out_push), .out_bin(out_bin), .out_bypass(out_bypass),
    .out_ctx(out_ctx), .out_bin_idx(out_bin_idx)
  );

  // method, value, param, k, chain, bypass, offset, row, bin count, suffix start (63 none), bins (bit i = bin i)
  localparam int NV = 18;
  localparam logic [87:0] VEC [NV] = '{
    {2'd0, 16'd3,      8'd0,  4'd0, 1'b0, 1'b0, 9'd10,  3'd2, 6'd4,  6'd63, 32'h7},
    {2'd0, 16'd0,      8'd0,  4'd0, 1'b0, 1'b0, 9'd0,   3'd0, 6'd1,  6'd63, 32'h0},
    {2'd1, 16'd2,      8'd5,  4'd0, 1'b0, 1'b0, 9'd100, 3'd1, 6'd3,  6'd63, 32'h3},
    {2'd1, 16'd5,      8'd5,  4'd0, 1'b0, 1'b0, 9'd40,  3'd3, 6'd5,  6'd63, 32'h1F},
    {2'd1, 16'd9,      8'd5,  4'd0, 1'b0, 1'b0, 9'd40,  3'd4, 6'd5,  6'd63, 32'h1F},
    {2'd2, 16'd0,      8'd0,  4'd0, 1'b0, 1'b0, 9'd7,   3'd5, 6'd1,  6'd63, 32'h0},
    {2'd2, 16'd3,      8'd0,  4'd0, 1'b0, 1'b1, 9'd7,   3'd5, 6'd5,  6'd63, 32'h3},
    {2'd2, 16'd5,      8'd0,  4'd1, 1'b0, 1'b0, 9'd200, 3'd6, 6'd4,  6'd63, 32'hD},
    {2'd2, 16'd1,      8'd0,  4'd2, 1'b0, 1'b0, 9'd30,  3'd0, 6'd3,  6'd63, 32'h4},
    {2'd3, 16'd10,     8'd4,  4'd0, 1'b0, 1'b0, 9'd60,  3'd1, 6'd4,  6'd63, 32'hA},
    {2'd3, 16'd10,     8'd0,  4'd0, 1'b0, 1'b0, 9'd60,  3'd1, 6'd0,  6'd63, 32'h0},
    {2'd1, 16'd5,      8'd3,  4'd0, 1'b1, 1'b0, 9'd80,  3'd2, 6'd6,  6'd3,  32'h2F},
    {2'd1, 16'd2,      8'd3,  4'd0, 1'b1, 1'b0, 9'd80,  3'd2, 6'd3,  6'd63, 32'h3},
    {2'd1, 16'd0,      8'd0,  4'd0, 1'b1, 1'b0, 9'd80,  3'd2, 6'd1,  6'd0,  32'h0},
    {2'd1, 16'd0,      8'd0,  4'd0, 1'b0, 1'b0, 9'd80,  3'd2, 6'd0,  6'd63, 32'h0},
    {2'd0, 16'd8,      8'd0,  4'd0, 1'b0, 1'b0, 9'd500, 3'd7, 6'd9,  6'd63, 32'hFF},
    {2'd2, 16'd20,     8'd0,  4'd3, 1'b0, 1'b1, 9'd0,   3'd0, 6'd6,  6'd63, 32'hD},
    {2'd3, 16'hBEEF,   8'd16, 4'd0, 1'b0, 1'b0, 9'd3,   3'd3, 6'd16, 6'd63, 32'hBEEF}
  };

  function automatic logic stall(int b, int i);
    if (i % 3 == 1) return b[0];
    if (i % 3 == 2) return (b % 3) == 0;
    return 1'b0;
  endfunction

  task automatic check(logic ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(int i);
    logic [87:0] v = VEC[i];
    int nb = int'(v[43:38]);
    int sfx = int'(v[37:32]);
    int got = 0;
    int budget = 0;
    logic ready_bad = 1'b0;
    string req;
    case (v[87:86])
      2'd0: req = "R1";
      2'd1: req = v[57] ? "R5" : "R2";
      2'd2: req = "R3";
      default: req = "R4";
    endcase
    @(negedge clk);
    check(in_ready, "R10", "ready before descriptor", int'(in_ready), 1);
    in_method = v[87:86]; in_value = v[85:70]; in_param = v[69:62];
    in_korder = v[61:58]; in_chain = v[57]; in_bypass = v[56];
    in_ctx_off = v[55:47]; in_ctx_row = v[46:44];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    while (got < nb && budget < 80) begin
      out_full = stall(budget, i);
      #1;
      if (!in_ready) ; else ready_bad = 1'b1;
      if (out_full) begin
        check(!out_push && out_bin_idx == 8'(got), "R9", "stall holds bin",
              int'(out_bin_idx), got);
      end else if (out_push) begin
        logic eb = v[got];
        logic eby = v[56] || (got >= sfx);
        int col = (got < 5) ? got : 5;
        int ectx = eby ? 0 : ((int'(v[55:47]) + int'(v[46:44]) + col) % 512);
        check(out_bin == eb, req, $sformatf("vec %0d bin %0d value", i, got), int'(out_bin), int'(eb));
        check(out_bin_idx == 8'(got), "R6", $sformatf("vec %0d index", i), int'(out_bin_idx), got);
        check(out_bypass == eby, "R8", $sformatf("vec %0d bin %0d bypass", i, got), int'(out_bypass), int'(eby));
        check(out_ctx == 9'(ectx), "R7", $sformatf("vec %0d bin %0d ctx", i, got), int'(out_ctx), ectx);
        got++;
      end
      budget++;
      if (got < nb) @(negedge clk);
    end
    if (nb > 0) check(!ready_bad, "R10", $sformatf("vec %0d ready low while busy", i), int'(ready_bad), 0);
    @(negedge clk);
    out_full = 1'b0;
    #1;
    check(got == nb, req, $sformatf("vec %0d bin count", i), got, nb);
    check(in_ready && !out_push, "R10", $sformatf("vec %0d idle after last bin", i), int'(in_ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(in_ready == 1'b1, "R11", "ready after reset", int'(in_ready), 1);
    check(out_push == 1'b0, "R11", "no push after reset", int'(out_push), 0);
    for (int i = 0; i < NV; i++) run_vec(i);

    // directed: long stall mid-element keeps the same bin (R9)
    @(negedge clk);
    in_method = 2'd0; in_value = 16'd4; in_param = '0; in_korder = '0;
    in_chain = 1'b0; in_bypass = 1'b0; in_ctx_off = 9'd1; in_ctx_row = 3'd1;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_push && out_bin_idx == 8'd0, "R6", "directed first bin", int'(out_bin_idx), 0);
    @(negedge clk);
    #1;
    check(out_bin_idx == 8'd1, "R6", "directed second bin", int'(out_bin_idx), 1);
    out_full = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    check(!out_push && out_bin_idx == 8'd1 && out_bin == 1'b1 && !in_ready, "R9",
          "held during long stall", int'(out_bin_idx), 1);
    out_full = 1'b0;
    for (int j = 1; j < 5; j++) begin
      #1;
      check(out_push && out_bin_idx == 8'(j) && out_bin == (j < 4), "R1",
            "bins after stall", int'(out_bin), int'(j < 4));
      @(negedge clk);
    end
    #1;
    check(in_ready && !out_push, "R10", "idle after directed element", int'(in_ready), 1);

    // directed: reset mid-element returns to idle (R11)
    in_method = 2'd0; in_value = 16'd10; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(in_ready && !out_push, "R11", "idle after mid-element reset", int'(in_ready), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule